// File: doc/BRIEF.md
# Segmented Paged Address Translation Walker

This block turns a 32-bit virtual address plus an access type into a physical address. The top bits of the address choose one of several sections. Each section has a descriptor-table base and a highest legal segment number, both supplied on input ports. The next field picks a segment descriptor. That descriptor is either contiguous, in which case the base plus the segment offset gives the physical address, or paged, in which case a page descriptor supplies the frame.

Descriptors are fetched one word at a time over a request/acknowledge read port, because every request is treated as a miss. Length, presence and permission checks run in a fixed order, and the first failure ends the walk with a fault code. The permission decision comes from an outside lookup: the block presents the descriptor's access field and the requested access type, and it reads back a single grant bit.

A request is taken only while the block is idle. The block answers with a one-cycle `done` pulse, and `err` qualifies it. A caller can clear the check-enable input for a debugger-style access. That skips the permission, write-protect and trap checks and leaves the latched virtual-address register alone.

Top module: `seg_xlate_top`

## Requirements
- R1: When `mmuOn` is 0, or the address lies in [IO_BASE, IO_BASE+IO_SPAN), `paddr` equals `reqVa` with no fault and no memory reads.
- R2: A segment number (va[29:17]) greater than the selected section's length raises code 1 before any memory read.
- R3: The segment descriptor is read as two words at tableBase+8*seg and tableBase+8*seg+4. Word 0 holds the flags: bit0 valid, bit1 present, bit2 contiguous, bit3 trap, bits 15:8 access field, bits 31:16 limit in 8-byte units. Word 1 holds the base. Valid=0 gives code 2.
- R4: A valid descriptor that is not present gives code 3 if it is contiguous and code 4 if it is paged.
- R5: For a paged segment the page descriptor is read at word1+4*page (page = va[16:11]). If 4*page is at or above the limit, code 5 is raised without that read.
- R6: With checks on, a denied lookup (access field, access type) gives code 6. This check precedes the offset checks and every page-descriptor check.
- R7: For a contiguous segment, an offset va[16:0] at or above the limit gives code 7. Otherwise the physical address is word1 + offset.
- R8: A page descriptor with bit0 = 0 gives code 8. Otherwise the physical address is {pd[31:11], va[10:0]}.
- R9: With checks on, a write (type 4) or an interlocked read (type 1) to a page whose descriptor has bit1 set gives code 9.
- R10: With checks on, a contiguous segment with its trap bit set gives code 10. The offset check is evaluated before it.
- R11: With checks off, the permission, page-write and trap checks are skipped.
- R12: A successful translation with checks on loads `varReg` with the address. A fault loads `faultCode` and `faultAddr` and leaves `varReg` unchanged.
- R13: `done` is a single-cycle pulse. `busy` is high from acceptance to completion, and `reqValid` is ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmuOn | input | 1 | Translation enable |
| sectBase | input | 32*NSECT | Descriptor-table base per section, section 0 in the low bits |
| sectLen | input | SEG_BITS*NSECT | Highest legal segment number per section |
| reqValid | input | 1 | Start a translation (sampled only while idle) |
| reqVa | input | 32 | Virtual address |
| reqAcc | input | 3 | Access type (1 interlocked read, 4 write) |
| reqCheck | input | 1 | Fault-check enable |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | Word read request, held until acknowledged |
| memAddr | output | 32 | Word read address |
| memAck | input | 1 | Read acknowledge; memData valid with it |
| memData | input | 32 | Read data |
| lookBits | output | 8 | Descriptor access field presented to the permission lookup |
| lookAcc | output | 3 | Requested access type presented to the lookup |
| lookOk | input | 1 | Lookup grant |
| done | output | 1 | Completion pulse |
| err | output | 1 | Completion ended in a fault |
| paddr | output | 32 | Last physical address |
| faultCode | output | 4 | Last fault code |
| faultAddr | output | 32 | Address of the last fault |
| varReg | output | 32 | Last successfully checked virtual address |

## Verification
The hardest cases to reach are the ones where two faults are true at once. Examples are a paged segment that denies access and also points at an absent page, a trapped contiguous segment whose offset is also out of range, and a write-protected page accessed with checks off. The descriptor memory in the stimulus is laid out so that single entries carry several faulting conditions at once, and the table of vectors probes each one with different access types and check settings. A separate directed test raises `reqValid` in the middle of a walk to confirm it is dropped, and read addresses are captured to confirm which descriptor words were fetched.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [3:0] {
    FLT_NONE        = 4'd0,
    FLT_TBL_LEN     = 4'd1,
    FLT_BAD_DESC    = 4'd2,
    FLT_SEG_ABSENT  = 4'd3,
    FLT_PT_ABSENT   = 4'd4,
    FLT_PT_LEN      = 4'd5,
    FLT_ACCESS      = 4'd6,
    FLT_SEG_OFF     = 4'd7,
    FLT_PAGE_ABSENT = 4'd8,
    FLT_PAGE_WRITE  = 4'd9,
    FLT_OBJ_TRAP    = 4'd10
  } fault_e;

  localparam logic [2:0] ACC_ILOCK = 3'd1;
  localparam logic [2:0] ACC_WRITE = 3'd4;

  // segment descriptor word 0 bit positions
  localparam int SD_VALID   = 0;
  localparam int SD_PRESENT = 1;
  localparam int SD_CONTIG  = 2;
  localparam int SD_TRAP    = 3;
  // page descriptor bit positions
  localparam int PD_PRESENT = 0;
  localparam int PD_WPROT   = 1;

  typedef enum logic [1:0] {MA_SD0, MA_SD1, MA_PD} maSel_e;

  typedef struct packed {
    logic   capture;
    logic   ldW0;
    logic   ldW1;
    logic   ldPd;
    logic   finOk;
    logic   finErr;
    logic   bypass;
    fault_e code;
    maSel_e maSel;
  } strobe_t;

  typedef struct packed {
    logic bypass;
    logic tblLenBad;
    logic sdValid;
    logic sdPresent;
    logic sdContig;
    logic sdTrap;
    logic segOffBad;
    logic ptOffBad;
    logic pdPresent;
    logic pdWprot;
    logic writeLike;
    logic chk;
  } status_t;

endpackage

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int SECT_BITS = 2,
  parameter int SEG_BITS  = 13,
  parameter int PG_BITS   = 6,
  parameter int OFF_BITS  = 11,
  parameter logic [31:0] IO_BASE = 32'hF000_0000,
  parameter logic [31:0] IO_SPAN = 32'h0100_0000,
  localparam int NSECT = 1 << SECT_BITS,
  localparam int SOFF_BITS = PG_BITS + OFF_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mmuOn,
  input  logic [32*NSECT-1:0]       sectBase,
  input  logic [SEG_BITS*NSECT-1:0] sectLen,
  input  logic [31:0]               reqVa,
  input  logic [2:0]                reqAcc,
  input  logic                      reqCheck,
  input  logic [31:0]               memData,
  input  strobe_t                   strb,
  output status_t                   stat,
  output logic [31:0]               memAddr,
  output logic [7:0]                lookBits,
  output logic [2:0]                lookAcc,
  output logic                      done,
  output logic                      err,
  output logic [31:0]               paddr,
  output logic [3:0]                faultCode,
  output logic [31:0]               faultAddr,
  output logic [31:0]               varReg
);

  logic [31:0] vaReg, w0, w1, pdReg;
  logic [2:0]  accReg;
  logic        chkReg;

  logic [31:0]         baseArr [NSECT];
  logic [SEG_BITS-1:0] lenArr  [NSECT];

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    assign baseArr[g] = sectBase[32*g +: 32];
    assign lenArr[g]  = sectLen[SEG_BITS*g +: SEG_BITS];
  end

  logic [SECT_BITS-1:0] sect;
  logic [SEG_BITS-1:0]  seg;
  logic [PG_BITS-1:0]   pg;
  logic [SOFF_BITS-1:0] segOff;
  logic [31:0]          sdAddr, ptOff, pdAddr, maxOff, paNext;
  logic                 isIo;

  assign sect   = vaReg[31 -: SECT_BITS];
  assign seg    = vaReg[SOFF_BITS +: SEG_BITS];
  assign pg     = vaReg[OFF_BITS +: PG_BITS];
  assign segOff = vaReg[SOFF_BITS-1:0];

  assign sdAddr = baseArr[sect] + (32'(seg) << 3);
  assign ptOff  = 32'(pg) << 2;
  assign pdAddr = w1 + ptOff;
  assign maxOff = {13'd0, w0[31:16], 3'b000};
  assign isIo   = (vaReg >= IO_BASE) &&
                  ({1'b0, vaReg} < ({1'b0, IO_BASE} + {1'b0, IO_SPAN}));

  always_comb begin
    stat.bypass    = !mmuOn || isIo;
    stat.tblLenBad = seg > lenArr[sect];
    stat.sdValid   = w0[SD_VALID];
    stat.sdPresent = w0[SD_PRESENT];
    stat.sdContig  = w0[SD_CONTIG];
    stat.sdTrap    = w0[SD_TRAP];
    stat.segOffBad = 32'(segOff) >= maxOff;
    stat.ptOffBad  = ptOff >= maxOff;
    stat.pdPresent = pdReg[PD_PRESENT];
    stat.pdWprot   = pdReg[PD_WPROT];
    stat.writeLike = (accReg == ACC_WRITE) || (accReg == ACC_ILOCK);
    stat.chk       = chkReg;
  end

  always_comb begin
    case (strb.maSel)
      MA_SD1:  memAddr = sdAddr + 32'd4;
      MA_PD:   memAddr = pdAddr;
      default: memAddr = sdAddr;
    endcase
  end

  always_comb begin
    if (strb.bypass)         paNext = vaReg;
    else if (w0[SD_CONTIG])  paNext = w1 + 32'(segOff);
    else                     paNext = {pdReg[31:OFF_BITS], vaReg[OFF_BITS-1:0]};
  end

  assign lookBits = w0[15:8];
  assign lookAcc  = accReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaReg <= '0; accReg <= '0; chkReg <= 1'b0;
      w0 <= '0; w1 <= '0; pdReg <= '0;
      done <= 1'b0; err <= 1'b0; paddr <= '0;
      faultCode <= '0; faultAddr <= '0; varReg <= '0;
    end else begin
      if (strb.capture) begin
        vaReg <= reqVa; accReg <= reqAcc; chkReg <= reqCheck;
      end
      if (strb.ldW0) w0 <= memData;
      if (strb.ldW1) w1 <= memData;
      if (strb.ldPd) pdReg <= memData;
      done <= strb.finOk || strb.finErr;
      if (strb.finOk) begin
        err   <= 1'b0;
        paddr <= paNext;
        if (chkReg) varReg <= vaReg;
      end else if (strb.finErr) begin
        err       <= 1'b1;
        faultCode <= strb.code;
        faultAddr <= vaReg;
      end
    end
  end

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (faultCode != 4'd0));
  // R12
  var_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.finErr |=> $stable(varReg));

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    memAck,
  input  logic    lookOk,
  input  status_t stat,
  output strobe_t strb,
  output logic    memReq,
  output logic    busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RD0, S_RD1, S_EVSD, S_RDPD, S_EVPD
  } state_e;

  state_e st, nxt;

  always_comb begin
    nxt  = st;
    strb = '0;
    strb.maSel = MA_SD0;
    strb.code  = FLT_NONE;
    case (st)
      S_IDLE: if (reqValid) begin strb.capture = 1'b1; nxt = S_START; end
      S_START: begin
        if (stat.bypass) begin
          strb.finOk = 1'b1; strb.bypass = 1'b1; nxt = S_IDLE;
        end else if (stat.tblLenBad) begin
          strb.finErr = 1'b1; strb.code = FLT_TBL_LEN; nxt = S_IDLE;
        end else nxt = S_RD0;
      end
      S_RD0: begin
        strb.maSel = MA_SD0;
        if (memAck) begin strb.ldW0 = 1'b1; nxt = S_RD1; end
      end
      S_RD1: begin
        strb.maSel = MA_SD1;
        if (memAck) begin strb.ldW1 = 1'b1; nxt = S_EVSD; end
      end
      S_EVSD: begin
        nxt = S_IDLE;
        strb.finErr = 1'b1;
        if (!stat.sdValid)              strb.code = FLT_BAD_DESC;
        else if (!stat.sdPresent)       strb.code = stat.sdContig ? FLT_SEG_ABSENT : FLT_PT_ABSENT;
        else if (stat.sdContig) begin
          if (stat.chk && !lookOk)      strb.code = FLT_ACCESS;
          else if (stat.segOffBad)      strb.code = FLT_SEG_OFF;
          else if (stat.chk && stat.sdTrap) strb.code = FLT_OBJ_TRAP;
          else begin strb.finErr = 1'b0; strb.finOk = 1'b1; end
        end else if (stat.ptOffBad)     strb.code = FLT_PT_LEN;
        else begin strb.finErr = 1'b0; nxt = S_RDPD; end
      end
      S_RDPD: begin
        strb.maSel = MA_PD;
        if (memAck) begin strb.ldPd = 1'b1; nxt = S_EVPD; end
      end
      S_EVPD: begin
        nxt = S_IDLE;
        strb.finErr = 1'b1;
        if (stat.chk && !lookOk)        strb.code = FLT_ACCESS;
        else if (!stat.pdPresent)       strb.code = FLT_PAGE_ABSENT;
        else if (stat.chk && stat.writeLike && stat.pdWprot) strb.code = FLT_PAGE_WRITE;
        else begin strb.finErr = 1'b0; strb.finOk = 1'b1; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  assign memReq = (st == S_RD0) || (st == S_RD1) || (st == S_RDPD);
  assign busy   = (st != S_IDLE);

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(strb.maSel)));
  // R13
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reqValid));

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import xlate_pkg::*;
#(
  parameter int SECT_BITS = 2,
  parameter int SEG_BITS  = 13,
  parameter int PG_BITS   = 6,
  parameter int OFF_BITS  = 11,
  parameter logic [31:0] IO_BASE = 32'hF000_0000,
  parameter logic [31:0] IO_SPAN = 32'h0100_0000,
  localparam int NSECT = 1 << SECT_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mmuOn,
  input  logic [32*NSECT-1:0]       sectBase,
  input  logic [SEG_BITS*NSECT-1:0] sectLen,
  input  logic                      reqValid,
  input  logic [31:0]               reqVa,
  input  logic [2:0]                reqAcc,
  input  logic                      reqCheck,
  output logic                      busy,
  output logic                      memReq,
  output logic [31:0]               memAddr,
  input  logic                      memAck,
  input  logic [31:0]               memData,
  output logic [7:0]                lookBits,
  output logic [2:0]                lookAcc,
  input  logic                      lookOk,
  output logic                      done,
  output logic                      err,
  output logic [31:0]               paddr,
  output logic [3:0]                faultCode,
  output logic [31:0]               faultAddr,
  output logic [31:0]               varReg
);

  strobe_t strb;
  status_t stat;

  xlate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .memAck(memAck),
    .lookOk(lookOk), .stat(stat), .strb(strb), .memReq(memReq), .busy(busy)
  );

  xlate_dpath #(
    .SECT_BITS(SECT_BITS), .SEG_BITS(SEG_BITS), .PG_BITS(PG_BITS),
    .OFF_BITS(OFF_BITS), .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .mmuOn(mmuOn), .sectBase(sectBase),
    .sectLen(sectLen), .reqVa(reqVa), .reqAcc(reqAcc), .reqCheck(reqCheck),
    .memData(memData), .strb(strb), .stat(stat), .memAddr(memAddr),
    .lookBits(lookBits), .lookAcc(lookAcc), .done(done), .err(err),
    .paddr(paddr), .faultCode(faultCode), .faultAddr(faultAddr),
    .varReg(varReg)
  );

endmodule

// File: tb/sim_seg_xlate_top.sv
`timescale 1ns/1ps
module sim_seg_xlate_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, mmuOn, reqValid, reqCheck, busy, memReq, memAck, lookOk;
  logic         done, err;
  logic [127:0] sectBase;
  logic [51:0]  sectLen;
  logic [31:0]  reqVa, memAddr, memData, paddr, faultAddr, varReg;
  logic [2:0]   reqAcc, lookAcc;
  logic [7:0]   lookBits;
  logic [3:0]   faultCode;

  seg_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .mmuOn(mmuOn), .sectBase(sectBase),
    .sectLen(sectLen), .reqValid(reqValid), .reqVa(reqVa), .reqAcc(reqAcc),
    .reqCheck(reqCheck), .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData), .lookBits(lookBits),
    .lookAcc(lookAcc), .lookOk(lookOk), .done(done), .err(err),
    .paddr(paddr), .faultCode(faultCode), .faultAddr(faultAddr),
    .varReg(varReg)
  );

  // descriptor memory and permission lookup
  logic [31:0] mem [256];
  assign lookOk = lookBits[lookAcc];
  always @(posedge clk) begin
    if (!rst_n) memAck <= 1'b0;
    else        memAck <= memReq && !memAck;
    memData <= mem[memAddr[9:2]];
  end

  int rdCnt = 0;
  logic [31:0] rdAddr [8];
  always @(posedge clk) if (memReq && memAck) begin
    if (rdCnt < 8) rdAddr[rdCnt] <= memAddr;
    rdCnt <= rdCnt + 1;
  end

  int doneCnt = 0;
  always @(negedge clk) if (done) doneCnt <= doneCnt + 1;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] expVar = 32'd0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic translate(input logic [31:0] va, input logic [2:0] acc, input logic chk);
    @(negedge clk);
    rdCnt = 0;
    reqVa = va; reqAcc = acc; reqCheck = chk; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  acc;
    logic        chk;
    logic [3:0]  code;
    logic [31:0] pa;
  } vec_t;

  localparam vec_t VECS [23] = '{
    '{32'h0000_0010, 3'd0, 1'b1, 4'd0,  32'h0001_0010}, // R7 contiguous ok
    '{32'h0000_0400, 3'd0, 1'b1, 4'd7,  32'h0},         // R7 offset at limit
    '{32'h0002_0004, 3'd0, 1'b1, 4'd0,  32'h0080_0004}, // R8 paged ok
    '{32'h0002_0804, 3'd0, 1'b1, 4'd0,  32'h0080_1004}, // R8 read of protected page
    '{32'h0002_0804, 3'd4, 1'b1, 4'd9,  32'h0},         // R9 write
    '{32'h0002_0804, 3'd1, 1'b1, 4'd9,  32'h0},         // R9 interlocked read
    '{32'h0002_0804, 3'd4, 1'b0, 4'd0,  32'h0080_1004}, // R11 write, checks off
    '{32'h0002_1000, 3'd0, 1'b1, 4'd8,  32'h0},         // R8 page absent
    '{32'h0002_2000, 3'd0, 1'b1, 4'd5,  32'h0},         // R5 page table length
    '{32'h0004_0008, 3'd0, 1'b1, 4'd10, 32'h0},         // R10 trap
    '{32'h0004_0008, 3'd0, 1'b0, 4'd0,  32'h0002_0008}, // R11 trap skipped
    '{32'h0004_0008, 3'd4, 1'b1, 4'd6,  32'h0},         // R6 denied write
    '{32'h0004_0400, 3'd4, 1'b1, 4'd6,  32'h0},         // R6 before offset
    '{32'h0004_0400, 3'd4, 1'b0, 4'd7,  32'h0},         // R11 access skipped
    '{32'h0006_0000, 3'd0, 1'b1, 4'd2,  32'h0},         // R3 invalid
    '{32'h0008_0000, 3'd0, 1'b1, 4'd1,  32'h0},         // R2 table length
    '{32'h4000_0000, 3'd0, 1'b1, 4'd3,  32'h0},         // R4 contiguous absent
    '{32'h4002_0000, 3'd0, 1'b1, 4'd4,  32'h0},         // R4 paged absent
    '{32'h8000_0004, 3'd4, 1'b1, 4'd6,  32'h0},         // R6 paged denied
    '{32'h8000_0004, 3'd0, 1'b1, 4'd0,  32'h0080_0004}, // R6 paged granted
    '{32'h8000_1000, 3'd4, 1'b1, 4'd6,  32'h0},         // R6 before page absent
    '{32'hF000_0123, 3'd4, 1'b1, 4'd0,  32'hF000_0123}, // R1 I/O window
    '{32'h0004_0400, 3'd0, 1'b1, 4'd7,  32'h0}          // R10 offset before trap
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[0]   = 32'h0080_FF07; mem[1] = 32'h0001_0000;
    mem[2]   = 32'h0002_FF03; mem[3] = 32'h0000_0100;
    mem[4]   = 32'h0080_010F; mem[5] = 32'h0002_0000;
    mem[64]  = 32'h0080_0001; mem[65] = 32'h0080_1003;
    mem[128] = 32'h0000_0005; mem[130] = 32'h0000_0001;
    mem[192] = 32'h0002_0103; mem[193] = 32'h0000_0100;
    sectBase = {32'h0, 32'h300, 32'h200, 32'h000};
    sectLen  = {13'd0, 13'd0, 13'd1, 13'd3};
    mmuOn = 1'b1; reqValid = 1'b0; reqVa = '0; reqAcc = '0; reqCheck = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 reset busy", {31'd0, busy}, 32'd0);
    check("R13 reset done", {31'd0, done}, 32'd0);
    check("R12 reset varReg", varReg, 32'd0);
    check("R12 reset faultCode", {28'd0, faultCode}, 32'd0);

    foreach (VECS[i]) begin
      translate(VECS[i].va, VECS[i].acc, VECS[i].chk);
      check($sformatf("R12 vec%0d err", i), {31'd0, err}, {31'd0, VECS[i].code != 4'd0});
      if (VECS[i].code != 4'd0) begin
        check($sformatf("R12 vec%0d code", i), {28'd0, faultCode}, {28'd0, VECS[i].code});
        check($sformatf("R12 vec%0d faultAddr", i), faultAddr, VECS[i].va);
      end else begin
        check($sformatf("R7 R8 vec%0d paddr", i), paddr, VECS[i].pa);
        if (VECS[i].chk) expVar = VECS[i].va;
      end
      check($sformatf("R12 vec%0d varReg", i), varReg, expVar);
      if (i == 15) check("R2 no reads", rdCnt, 0);
      if (i == 21) check("R1 io no reads", rdCnt, 0);
      if (i == 3) begin
        check("R3 sd word0 addr", rdAddr[0], 32'h08);
        check("R3 sd word1 addr", rdAddr[1], 32'h0C);
        check("R5 pd addr", rdAddr[2], 32'h104);
      end
      if (i == 8) check("R5 no pd read", rdCnt, 2);
    end

    // R1 translation disabled
    mmuOn = 1'b0;
    translate(32'h0006_0000, 3'd0, 1'b1);
    check("R1 off err", {31'd0, err}, 32'd0);
    check("R1 off paddr", paddr, 32'h0006_0000);
    check("R1 off no reads", rdCnt, 0);
    mmuOn = 1'b1;

    // R13 request ignored while busy, single done pulse
    @(negedge clk);
    doneCnt = 0;
    reqVa = 32'h0002_0804; reqAcc = 3'd0; reqCheck = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check("R13 busy mid-walk", {31'd0, busy}, 32'd1);
    reqVa = 32'h0000_0010; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    check("R13 first result kept", paddr, 32'h0080_1004);
    @(negedge clk);
    check("R13 done one cycle", {31'd0, done}, 32'd0);
    repeat (10) @(negedge clk);
    check("R13 single completion", doneCnt, 1);
    check("R13 idle after", {31'd0, busy}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule